// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches recent page translations so that an address can be translated in the same cycle as a parallel cache access. A lookup presents a segment identifier and an effective page number. The hit flag and the physical page number come back combinationally, with no register in the path. The buffer holds 64 entries arranged as 32 sets of two ways.

The buffer never fills itself. A lookup that misses captures the faulting page number and the way that hardware picks for replacement. Software reads both, searches the page table on its own, and then issues a reload. The reload writes the picked way of the set that the reload address indexes.

A supervisor invalidate clears both ways of one set, chosen by address. Each set keeps one recency bit, which steers the next replacement away from the way used most recently.

Top module: `tlb2w`

## Requirements
- R1: There are 32 sets of two ways. The set index is bits [4:0] of the effective page number. Two translations with the same index and different tags are held at the same time, one in each way, and both hit.
- R2: `lk_hit` and `lk_ppn` are combinational functions of the lookup inputs and the stored state. `lk_hit` is 0 whenever `lk_valid` is 0, and `lk_ppn` is 0 whenever `lk_hit` is 0.
- R3: The tag is the segment identifier together with page-number bits [19:5]. A lookup with a matching page number but a different segment identifier misses.
- R4: A reload writes its segment identifier, page number and physical page number into way `miss_way` of the set indexed by `rl_epn`. The entry hits from the next cycle on.
- R5: An invalidate clears both ways of the set indexed by `inv_epn[4:0]`, whatever their tags, effective from the next cycle. Other sets are untouched. When a reload and an invalidate target the same set in the same cycle, the invalidate wins.
- R6: A lookup with `lk_valid`=1 that misses loads `miss_epn` with `lk_epn`, and `miss_way` with the victim way, at the next clock edge. Both registers hold their values at every other edge.
- R7: The victim is chosen in this order: way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the set's least-recently-used way.
- R8: A hit in way w, or a reload into way w, makes the other way the set's least-recently-used way. A reload takes precedence over a hit update in the same cycle.
- R9: After reset every entry is invalid, and `miss_epn` and `miss_way` are both 0.
- R10: A miss changes no stored translation. Repeating the same lookup misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vsid | input | 24 | Lookup segment identifier |
| lk_epn | input | 20 | Lookup effective page number |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | 20 | Translated physical page number |
| rl_en | input | 1 | Software reload strobe |
| rl_vsid | input | 24 | Reload segment identifier |
| rl_epn | input | 20 | Reload effective page number |
| rl_ppn | input | 20 | Reload physical page number |
| inv_en | input | 1 | Selective invalidate strobe |
| inv_epn | input | 20 | Invalidate address page number |
| miss_epn | output | 20 | Page number of the last miss |
| miss_way | output | 1 | Replacement way chosen at the last miss |

## Verification
The hardest state to reach is a full set whose recency bit has to be read back, because that bit only shows up in `miss_way` after a miss on that set. The stimulus fills both ways of one set through miss-then-reload pairs. It then alternates a hit in one way with a miss by a third tag, and checks that the reported victim flips each time. The lookups made only to check results also move the recency bit, so the expected values follow every one of them. The bench also drives a reload and an invalidate at the same set in the same cycle, to check that the invalidate wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic {WAY0 = 1'b0, WAY1 = 1'b1} way_e;
   localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array #(
   parameter int unsigned SETS  = 32,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned TAG_W = 39,
   parameter int unsigned PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx,
   output logic             rd_hit,
   output logic             rd_vld,
   output logic [PPN_W-1:0] rd_ppn
);
   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PPN_W-1:0] ppn_q [SETS];

   // valid bits: invalidate is applied after the write so that it wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (wr_en)  vld_q[wr_idx]  <= 1'b1;
         if (inv_en) vld_q[inv_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(SETS); s++) begin
            tag_q[s] <= '0;
            ppn_q[s] <= '0;
         end
      end else if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         ppn_q[wr_idx] <= wr_ppn;
      end
   end

   always_comb begin
      rd_vld = vld_q[rd_idx];
      rd_hit = rd_vld && (tag_q[rd_idx] == rd_tag);
      rd_ppn = ppn_q[rd_idx];
   end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru
   import tlb_pkg::*;
#(
   parameter int unsigned SETS  = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             vld0,
   input  logic             vld1,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  way_e             upd_used,
   output way_e             victim
);
   // bit set means way 1 is the least recently used way of that set
   logic [SETS-1:0] lru_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (upd_en) begin
         lru_q[upd_idx] <= (upd_used == WAY0);
      end
   end

   always_comb begin
      if (!vld0)      victim = WAY0;
      else if (!vld1) victim = WAY1;
      else            victim = lru_q[rd_idx] ? WAY1 : WAY0;
   end
endmodule

// File: rtl/tlb2w.sv
module tlb2w
   import tlb_pkg::*;
#(
   parameter int unsigned SETS   = 32,
   parameter int unsigned EPN_W  = 20,
   parameter int unsigned VSID_W = 24,
   parameter int unsigned PPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VSID_W-1:0] lk_vsid,
   input  logic [EPN_W-1:0]  lk_epn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   input  logic              rl_en,
   input  logic [VSID_W-1:0] rl_vsid,
   input  logic [EPN_W-1:0]  rl_epn,
   input  logic [PPN_W-1:0]  rl_ppn,
   input  logic              inv_en,
   input  logic [EPN_W-1:0]  inv_epn,
   output logic [EPN_W-1:0]  miss_epn,
   output logic              miss_way
);
   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned TAG_W = VSID_W + EPN_W - IDX_W;

   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlb2w: SETS must be a power of two of at least 2");
   end
   if (EPN_W <= IDX_W) begin : g_bad_epn
      $error("tlb2w: EPN_W must exceed the index width");
   end

   logic [IDX_W-1:0] lk_idx, rl_idx, inv_idx;
   logic [TAG_W-1:0] lk_tag, rl_tag;
   assign lk_idx  = lk_epn[IDX_W-1:0];
   assign rl_idx  = rl_epn[IDX_W-1:0];
   assign inv_idx = inv_epn[IDX_W-1:0];
   assign lk_tag  = {lk_vsid, lk_epn[EPN_W-1:IDX_W]};
   assign rl_tag  = {rl_vsid, rl_epn[EPN_W-1:IDX_W]};

   logic [NUM_WAYS-1:0] hit_w, vld_w;
   logic [PPN_W-1:0]    ppn_w [NUM_WAYS];
   way_e                victim, miss_way_q;
   logic [EPN_W-1:0]    miss_epn_q;

   for (genvar w = 0; w < int'(NUM_WAYS); w++) begin : g_way
      tlb_way_array #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
      ) u_way (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_idx  (lk_idx),
         .rd_tag  (lk_tag),
         .wr_en   (rl_en && (miss_way_q == way_e'(w))),
         .wr_idx  (rl_idx),
         .wr_tag  (rl_tag),
         .wr_ppn  (rl_ppn),
         .inv_en  (inv_en),
         .inv_idx (inv_idx),
         .rd_hit  (hit_w[w]),
         .rd_vld  (vld_w[w]),
         .rd_ppn  (ppn_w[w])
      );
   end

   way_e hit_way;
   assign hit_way = hit_w[0] ? WAY0 : WAY1;
   assign lk_hit  = lk_valid && (|hit_w);
   assign lk_ppn  = !lk_hit ? '0 : (hit_w[0] ? ppn_w[0] : ppn_w[1]);

   tlb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .vld0     (vld_w[0]),
      .vld1     (vld_w[1]),
      .upd_en   (rl_en || lk_hit),
      .upd_idx  (rl_en ? rl_idx : lk_idx),
      .upd_used (rl_en ? miss_way_q : hit_way),
      .victim   (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         miss_epn_q <= '0;
         miss_way_q <= WAY0;
      end else if (lk_valid && !lk_hit) begin
         miss_epn_q <= lk_epn;
         miss_way_q <= victim;
      end
   end

   assign miss_epn = miss_epn_q;
   assign miss_way = miss_way_q;
endmodule

// File: rtl/tlb2w_chk.sv
module tlb2w_chk #(
   parameter int unsigned SETS   = 32,
   parameter int unsigned EPN_W  = 20,
   parameter int unsigned VSID_W = 24,
   parameter int unsigned PPN_W  = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [VSID_W-1:0] lk_vsid,
   input logic [EPN_W-1:0]  lk_epn,
   input logic              lk_hit,
   input logic [PPN_W-1:0]  lk_ppn,
   input logic              rl_en,
   input logic [VSID_W-1:0] rl_vsid,
   input logic [EPN_W-1:0]  rl_epn,
   input logic [PPN_W-1:0]  rl_ppn,
   input logic              inv_en,
   input logic [EPN_W-1:0]  inv_epn,
   input logic [EPN_W-1:0]  miss_epn,
   input logic              miss_way
);
   localparam int unsigned IDX_W = $clog2(SETS);

   p_hit_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppn == '0));

   p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit);

   p_miss_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit) |=> (miss_epn == $past(lk_epn)));

   p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_valid && !lk_hit) |=> ($stable(miss_epn) && $stable(miss_way)));

   p_reload_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rl_en && !inv_en) && $past(rst_n) && lk_valid &&
       lk_vsid == $past(rl_vsid) && lk_epn == $past(rl_epn))
      |-> (lk_hit && lk_ppn == $past(rl_ppn)));

   p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_en) && $past(rst_n) &&
       lk_epn[IDX_W-1:0] == $past(inv_epn[IDX_W-1:0])) |-> !lk_hit);
endmodule

bind tlb2w tlb2w_chk #(
   .SETS(SETS), .EPN_W(EPN_W), .VSID_W(VSID_W), .PPN_W(PPN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vsid(lk_vsid),
   .lk_epn(lk_epn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rl_en(rl_en),
   .rl_vsid(rl_vsid), .rl_epn(rl_epn), .rl_ppn(rl_ppn), .inv_en(inv_en),
   .inv_epn(inv_epn), .miss_epn(miss_epn), .miss_way(miss_way)
);

// File: tb/tb_tlb2w.sv
module tb_tlb2w;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [23:0] lk_vsid = '0;
   logic [19:0] lk_epn = '0;
   logic        lk_hit;
   logic [19:0] lk_ppn;
   logic        rl_en = 1'b0;
   logic [23:0] rl_vsid = '0;
   logic [19:0] rl_epn = '0;
   logic [19:0] rl_ppn = '0;
   logic        inv_en = 1'b0;
   logic [19:0] inv_epn = '0;
   logic [19:0] miss_epn;
   logic        miss_way;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   tlb2w dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vsid(lk_vsid),
      .lk_epn(lk_epn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rl_en(rl_en),
      .rl_vsid(rl_vsid), .rl_epn(rl_epn), .rl_ppn(rl_ppn), .inv_en(inv_en),
      .inv_epn(inv_epn), .miss_epn(miss_epn), .miss_way(miss_way)
   );

   localparam logic [23:0] V1 = 24'h000A11;
   localparam logic [23:0] V2 = 24'h000B22;
   localparam logic [19:0] EA = 20'h00123;  // set 3
   localparam logic [19:0] EB = 20'h00443;  // set 3
   localparam logic [19:0] EC = 20'h00863;  // set 3
   localparam logic [19:0] ED = 20'h00127;  // set 7
   localparam logic [19:0] EE = 20'h00129;  // set 9

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic look(input logic v, input logic [23:0] vs, input logic [19:0] ep,
                       output logic hit, output logic [19:0] ppn);
      @(negedge clk);
      lk_valid = v; lk_vsid = vs; lk_epn = ep;
      #1;
      hit = lk_hit; ppn = lk_ppn;
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic reload(input logic [23:0] vs, input logic [19:0] ep,
                         input logic [19:0] pp, input logic with_inv);
      @(negedge clk);
      rl_en = 1'b1; rl_vsid = vs; rl_epn = ep; rl_ppn = pp;
      inv_en = with_inv; inv_epn = ep;
      @(posedge clk);
      #1 rl_en = 1'b0; inv_en = 1'b0;
   endtask

   task automatic invalidate(input logic [19:0] ep);
      @(negedge clk);
      inv_en = 1'b1; inv_epn = ep;
      @(posedge clk);
      #1 inv_en = 1'b0;
   endtask

   task automatic t_reset();
      logic h; logic [19:0] p;
      chk(miss_epn == 20'h0, "R9 miss_epn", miss_epn, 0);
      chk(miss_way == 1'b0, "R9 miss_way", miss_way, 0);
      look(1'b1, V1, EA, h, p);
      chk(!h, "R9 empty after reset", h, 0);
      chk(p == 20'h0, "R2 ppn zero on miss", p, 0);
   endtask

   task automatic t_fill_set();
      logic h; logic [19:0] p;
      chk(miss_epn == EA, "R6 miss_epn captured", miss_epn, EA);
      chk(miss_way == 1'b0, "R7 first victim way0", miss_way, 0);
      reload(V1, EA, 20'hAAAAA, 1'b0);
      look(1'b1, V1, EA, h, p);
      chk(h && p == 20'hAAAAA, "R4 reload visible", p, 20'hAAAAA);
      look(1'b1, V1, EB, h, p);
      chk(!h, "R1 second tag misses", h, 0);
      chk(miss_way == 1'b1, "R7 invalid way1 chosen", miss_way, 1);
      reload(V1, EB, 20'hBBBBB, 1'b0);
      look(1'b1, V1, EB, h, p);
      chk(h && p == 20'hBBBBB, "R1 way1 entry hits", p, 20'hBBBBB);
      look(1'b1, V1, EA, h, p);
      chk(h && p == 20'hAAAAA, "R1 way0 entry still hits", p, 20'hAAAAA);
   endtask

   task automatic t_lru();
      logic h; logic [19:0] p;
      // last hit was way0, so way1 is LRU
      look(1'b1, V1, EC, h, p);
      chk(miss_way == 1'b1, "R8 victim after way0 hit", miss_way, 1);
      look(1'b1, V1, EB, h, p);
      look(1'b1, V1, EC, h, p);
      chk(miss_way == 1'b0, "R8 victim after way1 hit", miss_way, 0);
      chk(!h, "R10 repeated miss still misses", h, 0);
      look(1'b1, V2, EA, h, p);
      chk(!h, "R3 other segment misses", h, 0);
      look(1'b0, V1, EA, h, p);
      chk(!h, "R2 no hit without request", h, 0);
   endtask

   task automatic t_invalidate();
      logic h; logic [19:0] p;
      look(1'b1, V1, ED, h, p);
      chk(miss_way == 1'b0, "R7 empty set picks way0", miss_way, 0);
      reload(V1, ED, 20'hDDDDD, 1'b0);
      invalidate(20'hFFF03);
      look(1'b1, V1, EA, h, p);
      chk(!h, "R5 way0 cleared", h, 0);
      chk(miss_way == 1'b0, "R7 cleared set refills way0", miss_way, 0);
      look(1'b1, V1, EB, h, p);
      chk(!h, "R5 way1 cleared", h, 0);
      look(1'b1, V1, ED, h, p);
      chk(h && p == 20'hDDDDD, "R5 other set kept", p, 20'hDDDDD);
      chk(miss_epn == EB, "R6 hold on hit", miss_epn, EB);
      @(negedge clk); @(negedge clk);
      chk(miss_epn == EB, "R6 hold when idle", miss_epn, EB);
   endtask

   task automatic t_collision();
      logic h; logic [19:0] p;
      look(1'b1, V1, EE, h, p);
      reload(V1, EE, 20'hEEEEE, 1'b1);
      look(1'b1, V1, EE, h, p);
      chk(!h, "R5 invalidate beats reload", h, 0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_set();
      t_lru();
      t_invalidate();
      t_collision();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule